// File: doc/BRIEF.md
# Cascadable Programmable Post-Scale Divider

This block divides a fast source clock by a programmable integer. The ratio is not given as one number. It is given as two counts: how many counting edges the output stays high, and how many it stays low. A half-step select lengthens the high phase by half a source cycle and shortens the low phase by the same amount. The duty cycle can therefore be placed in steps of 50% divided by the ratio. Setting the low count to zero selects a bypass mode, in which the output follows the counting clock unchanged.

Identical dividers can be chained. A divider whose cascade select is set counts rising edges of its cascade input, which carries the previous divider's output, instead of counting source-clock edges. A chained pair behaves as one divider whose ratio is the product of the two settings. The cascade select is captured only while reset is asserted. Counts written at runtime are latched at the start of each output period, so a period is never cut short or stretched partway through.

Top module: `postscale_div`

## Requirements
- R1: With low count L ≥ 1, half select 0 and cascade off, the output is high for H source cycles and low for L source cycles, so the period is H+L cycles. Every high phase starts on a rising source edge. A high count of 0 is treated as 1.
- R2: With half select 1 and cascade off, the high phase lasts 2H+1 source half-cycles and the low phase lasts 2L−1. The output stays free of glitches and runt pulses.
- R3: A low count of 0 selects bypass. The output equals the counting clock: the source clock, or the cascade input when cascade is on. The high count and the half select have no effect in bypass.
- R4: Counts changed in the middle of a period take effect only at the next period boundary. The current period completes with the old counts.
- R5: While rst_ni is low, the output is low. After release, the high phase of the first period begins on the first counting edge.
- R6: With cascade on, the divider counts rising edges of cascade_i, which must come from a divider with a ratio of at least 2. A chain of settings 2+2 and 3+2 has a period of 20 source cycles: 12 cycles high and 8 cycles low.
- R7: The cascade select is sampled only on clock edges while rst_ni is low. Changes made after reset is released are ignored.
- R8: The half select has no effect while cascade is on.
- R9: The high and low counts each reach 511 and the ratio reaches 512. Settings of 256+256, and 511+1 with the half step, divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| high_i | input | CNT_W | High-phase count, in counting edges |
| low_i | input | CNT_W | Low-phase count; 0 selects bypass |
| half_i | input | 1 | Extends the high phase by half a source cycle |
| cascade_en_i | input | 1 | Chain select, captured while in reset |
| cascade_i | input | 1 | Output of the previous divider in the chain |
| div_o | output | 1 | Divided clock |

## Verification
The bench samples the output once per source half-cycle and measures the high and low widths. A falling-edge extension that leaves a gap, or one that misfires, shows up as a high width that is off by one half-cycle. A mid-period count change is checked against the period already in flight: a divider that reloads immediately would return a truncated or stretched period there. The chained pair is checked for the product ratio, for ignoring the half step, for bypass through the cascade input, and for keeping the cascade select when it is toggled at runtime. A divider that re-sampled the select after reset would fall back to the source clock and give a width of 6 half-cycles instead of 24. The extreme settings 256+256 and 511+1 with the half step would expose a counter that is too narrow or a reload that is off by one.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int DEF_MAX_RATIO = 512;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/psd_tick_gen.sv
module psd_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic casc_i,
  input  logic cascade_i,
  output logic tick_o
);
  logic casc_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_d_q <= 1'b0;
    else         casc_d_q <= cascade_i;
  end

  // one tick per rising edge of the upstream divider, else every cycle
  assign tick_o = casc_i ? (cascade_i & ~casc_d_q) : 1'b1;
endmodule

// File: rtl/psd_period_ctr.sv
module psd_period_ctr import psd_pkg::*; #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             casc_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic             half_i,
  output logic             pos_o,
  output logic             half_o,
  output logic             byp_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, lo_q;
  logic             half_q, byp_q, pos_q;
  logic             last, start;
  logic [CNT_W-1:0] hi_eff;

  assign last   = (cnt_q == CNT_W'(1)) || byp_q;
  assign start  = tick_i && last && (phase_q == PH_LOW || byp_q);
  assign hi_eff = (high_i == '0) ? CNT_W'(1) : high_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      cnt_q   <= CNT_W'(1);
      lo_q    <= CNT_W'(1);
      half_q  <= 1'b0;
      byp_q   <= 1'b0;
      pos_q   <= 1'b0;
    end else if (start) begin
      // period boundary: latch new settings
      phase_q <= PH_HIGH;
      pos_q   <= 1'b1;
      cnt_q   <= hi_eff;
      lo_q    <= low_i;
      byp_q   <= (low_i == '0);
      half_q  <= half_i & ~casc_i & (low_i != '0);
    end else if (tick_i && last) begin
      phase_q <= PH_LOW;
      pos_q   <= 1'b0;
      cnt_q   <= lo_q;
    end else if (tick_i) begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign pos_o  = pos_q;
  assign half_o = half_q;
  assign byp_o  = byp_q;

  // R1
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
  // R2
  pos_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pos_q));
  // R4
  cfg_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(lo_q) && $stable(half_q) && $stable(byp_q)));
endmodule

// File: rtl/psd_half_ext.sv
module psd_half_ext (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic half_i,
  input  logic byp_i,
  input  logic src_clk_i,
  output logic div_o
);
  logic neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= pos_i;
  end

  // OR with half-cycle delayed copy: extension without a gap
  assign div_o = byp_i ? src_clk_i : (pos_i | (half_i & neg_q));

  // R2
  neg_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_q == pos_i);
endmodule

// File: rtl/postscale_div.sv
module postscale_div import psd_pkg::*; #(
  parameter  int MAX_RATIO = DEF_MAX_RATIO,
  localparam int CNT_W     = $clog2(MAX_RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] high_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic             half_i,
  input  logic             cascade_en_i,
  input  logic             cascade_i,
  output logic             div_o
);
  logic casc_q, tick, pos, half_x, byp, src_clk;

  // static chain select, loaded only during reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) casc_q <= cascade_en_i;
  end

  assign src_clk = casc_q ? cascade_i : clk_i;

  psd_tick_gen u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .casc_i   (casc_q),
    .cascade_i(cascade_i),
    .tick_o   (tick)
  );

  psd_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .casc_i(casc_q),
    .high_i(high_i),
    .low_i (low_i),
    .half_i(half_i),
    .pos_o (pos),
    .half_o(half_x),
    .byp_o (byp)
  );

  psd_half_ext u_ext (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos),
    .half_i   (half_x),
    .byp_i    (byp),
    .src_clk_i(src_clk),
    .div_o    (div_o)
  );

  // R7
  casc_static_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(casc_q));
  // R8
  no_half_cascaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_q |-> !half_x);
endmodule

// File: tb/postscale_div_tb.sv
`timescale 1ns/1ps
module postscale_div_tb;
  localparam int CNT_W = 9;
  localparam int NV = 10;
  // high, low, half, expected high / low widths in half-cycles
  localparam int VH [NV] = '{2, 3, 3, 1, 1, 5, 1, 4, 256, 511};
  localparam int VL [NV] = '{2, 5, 5, 1, 1, 2, 0, 0, 256, 1};
  localparam int VF [NV] = '{0, 0, 1, 0, 1, 1, 0, 1, 0, 1};
  localparam int EH [NV] = '{4, 6, 7, 2, 3, 11, 1, 1, 512, 1023};
  localparam int EL [NV] = '{4, 10, 9, 2, 1, 3, 1, 1, 512, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] high, low;
  logic half = 1'b0, casc_en = 1'b0;
  logic src_o, div_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  postscale_div u_src (
    .clk_i(clk), .rst_ni(rst_n), .high_i(9'd2), .low_i(9'd2), .half_i(1'b0),
    .cascade_en_i(1'b0), .cascade_i(1'b0), .div_o(src_o));

  postscale_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .high_i(high), .low_i(low), .half_i(half),
    .cascade_en_i(casc_en), .cascade_i(src_o), .div_o(div_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic get_s(output logic s);
    @(clk);
    #2.5;
    s = div_o;
  endtask

  task automatic sync_rise();
    logic p, s;
    get_s(s);
    do begin
      p = s;
      get_s(s);
    end while (!(s && !p));
  endtask

  task automatic measure(output int hi, output int lo);
    logic s;
    hi = 1;
    get_s(s);
    while (s) begin hi++; get_s(s); end
    lo = 1;
    get_s(s);
    while (!s) begin lo++; get_s(s); end
  endtask

  task automatic set_cfg(input int h, input int l, input int f);
    high = CNT_W'(h);
    low  = CNT_W'(l);
    half = f[0];
  endtask

  initial begin
    int hi, lo;
    logic s;
    set_cfg(3, 5, 0);
    // R5 output low during reset
    for (int i = 0; i < 6; i++) begin
      get_s(s);
      check("R5 low in reset", int'(s), 0);
    end
    do get_s(s); while (clk);
    rst_n = 1'b1;
    get_s(s);
    check("R5 first edge rise", int'(s), 1);
    measure(hi, lo);
    check("R1 first high", hi, 6);
    check("R1 first low", lo, 10);

    // table: R1 R2 R3 R9
    for (int v = 0; v < NV; v++) begin
      set_cfg(VH[v], VL[v], VF[v]);
      sync_rise();
      measure(hi, lo);
      check($sformatf("R1/R2/R3/R9 vec%0d high", v), hi, EH[v]);
      check($sformatf("R1/R2/R3/R9 vec%0d low", v), lo, EL[v]);
    end

    // R4 mid-period change
    set_cfg(4, 4, 0);
    sync_rise();
    sync_rise();
    set_cfg(2, 6, 0);
    measure(hi, lo);
    check("R4 old period high", hi, 8);
    check("R4 old period low", lo, 8);
    measure(hi, lo);
    check("R4 new period high", hi, 4);
    check("R4 new period low", lo, 12);

    // R5 reset mid-run
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      get_s(s);
      check("R5 low in mid-run reset", int'(s), 0);
    end
    do get_s(s); while (clk);
    rst_n = 1'b1;
    get_s(s);
    check("R5 rise after release", int'(s), 1);
    measure(hi, lo);
    check("R5 restart high", hi, 4);

    // R6 cascade: captured during reset
    set_cfg(3, 2, 1);
    casc_en = 1'b1;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) get_s(s);
    rst_n = 1'b1;
    sync_rise();
    measure(hi, lo);
    check("R6 cascade high", hi, 24);
    check("R6 cascade low", lo, 16);
    check("R8 half ignored in cascade", hi + lo, 40);

    // R7 runtime change of select ignored
    casc_en = 1'b0;
    set_cfg(3, 2, 0);
    sync_rise();
    measure(hi, lo);
    check("R7 select held high", hi, 24);
    check("R7 select held low", lo, 16);

    // R3 bypass follows cascade input
    set_cfg(7, 0, 1);
    sync_rise();
    sync_rise();
    measure(hi, lo);
    check("R3 cascade bypass high", hi, 4);
    check("R3 cascade bypass low", lo, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule